// File: doc/BRIEF.md
# Staged Bit Permutation Unit

This unit rearranges the bits of a 64-bit word using a single chain of mask-driven exchange stages, one stage for each power of two. Four operations share those stages. Generalized reverse swaps neighbouring bit groups. Generalized OR-combine merges each group with its swapped partner. Perfect shuffle interleaves the two halves of blocks, and unshuffle undoes that interleave. A control amount switches individual stages on or off. The operations differ only in two ways: whether a stage replaces the word or ORs into it, and the order in which the stages are walked.

Each operation is issued with a valid strobe, an operation code, a control amount, a data word and a word-mode flag. Word mode limits the operation to the low 32 bits and sign-extends the result. The result is registered, so it appears one clock after issue. The register holds its value until the next valid issue.

Top module: `bperm_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: A result and `out_valid`=1 appear on the first rising edge after `in_valid`=1 is sampled. `out_valid` is 0 one cycle after an edge that sampled `in_valid`=0.
- R3: When `in_valid` is 0, `result` keeps its previous value, whatever the other inputs are.
- R4: With `op`=0 (generalized reverse), result bit i equals input bit (i XOR amount). Stage 2^k swaps the bit groups selected by amount bit k.
- R5: Generalized reverse with every amount bit set reverses the bit order of the whole word.
- R6: With `op`=1 (OR-combine), result bit i is the OR of input bits (i XOR s) over every s whose set bits are a subset of the amount. The result therefore always covers the input.
- R7: OR-combine with amount 7 turns each byte that has any bit set into 0xFF and leaves zero bytes at zero.
- R8: With `op`=2 (shuffle), the stages 16, 8, 4, 2, 1 are applied in that order, each enabled by amount bit 4 down to 0. Stage 2^k exchanges index bits k and k+1. Amount bit 5 has no effect.
- R9: With `op`=3 (unshuffle), the same stages are applied in the order 1, 2, 4, 8, 16. Unshuffle with amount a undoes shuffle with amount a.
- R10: With `word_mode`=1, only the low 32 bits take part. The top reverse/OR-combine stage (32) and the top shuffle stage (16) are disabled. `result[63:32]` is a copy of `result[31]`, and input bits 63:32 have no effect.
- R11: Amount 0 returns the input unchanged for every operation, outside word mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for the operands below |
| op | input | 2 | 0 reverse, 1 OR-combine, 2 shuffle, 3 unshuffle |
| word_mode | input | 1 | Restrict the operation to the low 32 bits and sign-extend |
| amount | input | 6 | Stage enable bits, bit k drives stage 2^k |
| data_in | input | 64 | Word to permute |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 64 | Registered permuted word |

## Verification
Two things can land in one cycle. The result register can load a new operation while a different operation and mode are being presented for the next edge. Word mode can also clip a stage that the amount bits request. The bench issues every operation, amount and mode back to back, so the operation code, amount and word flag change on every edge. Each output is compared with a bench model that works on bit indices rather than masks, including the case where amount bit 5 (or bit 4 for shuffle) is set in word mode and must be ignored.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
    typedef enum logic [1:0] {
        BP_GREV   = 2'd0,
        BP_GORC   = 2'd1,
        BP_SHFL   = 2'd2,
        BP_UNSHFL = 2'd3
    } bp_op_e;
endpackage

// File: rtl/bperm_xchg_net.sv
// Butterfly chain shared by generalized reverse and OR-combine.
module bperm_xchg_net #(
    parameter int XLEN   = 64,
    parameter int STAGES = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]   din,
    input  logic [STAGES-1:0] en,
    input  logic              or_merge,
    output logic [XLEN-1:0]   dout
);
    // bit i selected when index bit k is clear (lower partner of a pair)
    function automatic logic [XLEN-1:0] lo_mask(input int k);
        logic [XLEN-1:0] m;
        for (int i = 0; i < XLEN; i++) m[i] = (((i >> k) & 1) == 0);
        return m;
    endfunction

    logic [XLEN-1:0] lvl [STAGES+1];
    assign lvl[0] = din;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int              SH = 1 << k;
        localparam logic [XLEN-1:0] LO = lo_mask(k);
        logic [XLEN-1:0] swp;
        assign swp        = ((lvl[k] & LO) << SH) | ((lvl[k] & ~LO) >> SH);
        assign lvl[k+1]   = !en[k] ? lvl[k] : (or_merge ? (lvl[k] | swp) : swp);
    end

    assign dout = lvl[STAGES];
endmodule

// File: rtl/bperm_shuf_net.sv
// Shuffle stages walked downward (shuffle) or upward (unshuffle).
module bperm_shuf_net #(
    parameter int XLEN = 64,
    parameter int SS   = $clog2(XLEN) - 1
) (
    input  logic [XLEN-1:0] din,
    input  logic [SS-1:0]   en,
    input  logic            inverse,
    output logic [XLEN-1:0] dout
);
    // destination of the upward move: index bits (k+1,k) == 2'b10
    function automatic logic [XLEN-1:0] up_mask(input int k);
        logic [XLEN-1:0] m;
        for (int i = 0; i < XLEN; i++) m[i] = (((i >> k) & 3) == 2);
        return m;
    endfunction
    // destination of the downward move: index bits (k+1,k) == 2'b01
    function automatic logic [XLEN-1:0] dn_mask(input int k);
        logic [XLEN-1:0] m;
        for (int i = 0; i < XLEN; i++) m[i] = (((i >> k) & 3) == 1);
        return m;
    endfunction

    logic [XLEN-1:0] fw [SS+1];
    logic [XLEN-1:0] rv [SS+1];
    assign fw[0] = din;
    assign rv[0] = din;

    for (genvar t = 0; t < SS; t++) begin : g_step
        localparam int              KF  = SS - 1 - t;
        localparam int              NF  = 1 << KF;
        localparam logic [XLEN-1:0] LF  = up_mask(KF);
        localparam logic [XLEN-1:0] RF  = dn_mask(KF);
        localparam int              NR  = 1 << t;
        localparam logic [XLEN-1:0] LR  = up_mask(t);
        localparam logic [XLEN-1:0] RR  = dn_mask(t);
        logic [XLEN-1:0] fx, rx;
        assign fx = (fw[t] & ~(LF | RF)) | ((fw[t] << NF) & LF) | ((fw[t] >> NF) & RF);
        assign rx = (rv[t] & ~(LR | RR)) | ((rv[t] << NR) & LR) | ((rv[t] >> NR) & RR);
        assign fw[t+1] = en[KF] ? fx : fw[t];
        assign rv[t+1] = en[t]  ? rx : rv[t];
    end

    assign dout = inverse ? rv[SS] : fw[SS];
endmodule

// File: rtl/bperm_unit.sv
module bperm_unit #(
    parameter int XLEN = 64,
    parameter int AW   = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic            word_mode,
    input  logic [AW-1:0]   amount,
    input  logic [XLEN-1:0] data_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);
    import bperm_pkg::*;

    localparam int HALF = XLEN / 2;
    localparam int SS   = AW - 1;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] data;
    } state_t;

    state_t st_d, st_q;

    bp_op_e          op_e;
    logic [AW-1:0]   xchg_en;
    logic [SS-1:0]   shuf_en;
    logic [XLEN-1:0] xchg_out, shuf_out;

    assign op_e    = bp_op_e'(op);
    assign xchg_en = amount & (word_mode ? {1'b0, {(AW-1){1'b1}}} : {AW{1'b1}});
    assign shuf_en = amount[SS-1:0] & (word_mode ? {1'b0, {(SS-1){1'b1}}} : {SS{1'b1}});

    bperm_xchg_net #(.XLEN(XLEN), .STAGES(AW)) u_xchg (
        .din      (data_in),
        .en       (xchg_en),
        .or_merge (op_e == BP_GORC),
        .dout     (xchg_out)
    );

    bperm_shuf_net #(.XLEN(XLEN), .SS(SS)) u_shuf (
        .din     (data_in),
        .en      (shuf_en),
        .inverse (op_e == BP_UNSHFL),
        .dout    (shuf_out)
    );

    always_comb begin
        logic [XLEN-1:0] raw;
        st_d       = st_q;
        st_d.valid = in_valid;
        raw        = (op_e == BP_GREV || op_e == BP_GORC) ? xchg_out : shuf_out;
        if (in_valid) begin
            if (word_mode) st_d.data = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
            else           st_d.data = raw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.data;
endmodule

module bperm_unit_chk #(
    parameter int XLEN = 64,
    parameter int AW   = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      op,
    input logic            word_mode,
    input logic [AW-1:0]   amount,
    input logic [XLEN-1:0] data_in,
    input logic            out_valid,
    input logic [XLEN-1:0] result
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] rev_in;
    always_comb for (int i = 0; i < XLEN; i++) rev_in[i] = data_in[XLEN-1-i];

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    a_r5_full_reverse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0 && !word_mode && amount == {AW{1'b1}})
        |=> result == $past(rev_in));
    a_r6_covers_input: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd1 && !word_mode)
        |=> (result & $past(data_in)) == $past(data_in));
    a_r10_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && word_mode)
        |=> result[XLEN-1:HALF] == {HALF{result[HALF-1]}});
    a_r11_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !word_mode && amount == '0)
        |=> result == $past(data_in));
endmodule

bind bperm_unit bperm_unit_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .word_mode(word_mode), .amount(amount), .data_in(data_in),
    .out_valid(out_valid), .result(result)
);

// File: tb/bperm_unit_tb.sv
module bperm_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        word_mode = 1'b0;
    logic [5:0]  amount = 6'd0;
    logic [63:0] data_in = 64'd0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    bperm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .word_mode(word_mode), .amount(amount), .data_in(data_in),
        .out_valid(out_valid), .result(result)
    );

    // swap index bits k and k+1 for every bit below wd
    function automatic logic [63:0] idx_swap(input logic [63:0] y, input int k, input int wd);
        logic [63:0] z;
        z = y;
        for (int i = 0; i < wd; i++) begin
            int j;
            j = i;
            if (((i >> k) & 1) != ((i >> (k + 1)) & 1)) j = i ^ (3 << k);
            z[j] = y[i];
        end
        return z;
    endfunction

    function automatic logic [63:0] model(input logic [1:0] o, input logic w,
                                          input logic [5:0] amt, input logic [63:0] x);
        logic [63:0] r;
        int wd, ns, a;
        wd = w ? 32 : 64;
        ns = w ? 4 : 5;
        a  = w ? int'(amt & 6'd31) : int'(amt);
        r  = x;
        case (o)
            2'd0: for (int i = 0; i < wd; i++) r[i] = x[i ^ a];
            2'd1: for (int i = 0; i < wd; i++) begin
                r[i] = 1'b0;
                for (int s = 0; s < 64; s++)
                    if ((s & ~a) == 0 && (i ^ s) < wd) r[i] = r[i] | x[i ^ s];
            end
            2'd2: for (int k = ns - 1; k >= 0; k--) if (((a >> k) & 1) == 1) r = idx_swap(r, k, wd);
            default: for (int k = 0; k < ns; k++) if (((a >> k) & 1) == 1) r = idx_swap(r, k, wd);
        endcase
        if (w) r = {{32{r[31]}}, r[31:0]};
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // present operands at a falling edge, read result at the next falling edge
    task automatic issue(input logic [1:0] o, input logic w, input logic [5:0] amt,
                         input logic [63:0] d, output logic [63:0] got);
        in_valid = 1'b1; op = o; word_mode = w; amount = amt; data_in = d;
        @(negedge clk);
        check("R2 out_valid after issue", {63'd0, out_valid}, 64'd1);
        got = result;
    endtask

    function automatic string op_tag(input logic [1:0] o, input logic w, input logic [5:0] amt);
        if (w) return "R10 word mode";
        if (amt == 6'd0) return "R11 zero amount";
        case (o)
            2'd0: return "R4 reverse";
            2'd1: return "R6 or-combine";
            2'd2: return "R8 shuffle";
            default: return "R9 unshuffle";
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] got, got2, last, d;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 result in reset", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
        check("R1 result after reset", result, 64'd0);

        // back-to-back sweep of every op, mode and amount
        for (int p = 0; p < 3; p++) begin
            for (int w = 0; w < 2; w++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int a = 0; a < 64; a++) begin
                        seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
                        d = (p == 0) ? 64'h0123_4567_89AB_CDEF : (p == 1) ? 64'h8000_0000_0000_0001 : seed;
                        issue(o[1:0], w[0], a[5:0], d, got);
                        check(op_tag(o[1:0], w[0], a[5:0]), got, model(o[1:0], w[0], a[5:0], d));
                    end
                end
            end
        end

        // R5 full reverse
        issue(2'd0, 1'b0, 6'd63, 64'h0000_0000_0000_0001, got);
        check("R5 full reverse", got, 64'h8000_0000_0000_0000);
        issue(2'd0, 1'b0, 6'd63, 64'h0123_4567_89AB_CDEF, got);
        check("R5 full reverse pattern", got, 64'hF7B3_D591_E6A2_C480);

        // R7 byte or-combine
        issue(2'd1, 1'b0, 6'd7, 64'h0010_0000_8000_0201, got);
        check("R7 byte or-combine", got, 64'h00FF_0000_FF00_FFFF);

        // R8 amount bit 5 ignored by shuffle
        issue(2'd2, 1'b0, 6'd21, 64'hDEAD_BEEF_0F1E_2D3C, got);
        issue(2'd2, 1'b0, 6'd53, 64'hDEAD_BEEF_0F1E_2D3C, got2);
        check("R8 shuffle ignores amount bit 5", got2, got);

        // R9 round trip
        for (int a = 1; a < 32; a += 5) begin
            d = 64'hC3A5_0F96_1234_FEDC ^ (64'(a) << 40);
            issue(2'd2, 1'b0, a[5:0], d, got);
            issue(2'd3, 1'b0, a[5:0], got, got2);
            check("R9 unshuffle undoes shuffle", got2, d);
        end

        // R10 upper input ignored, sign extension
        issue(2'd0, 1'b1, 6'd31, 64'h1234_5678_0000_0001, got);
        check("R10 word reverse sign-extended", got, 64'hFFFF_FFFF_8000_0000);
        issue(2'd0, 1'b1, 6'd63, 64'hFFFF_FFFF_0000_0002, got);
        check("R10 word mode clips stage 32", got, 64'h0000_0000_4000_0000);

        // R3 hold while idle, with changed inputs
        issue(2'd1, 1'b0, 6'd3, 64'h0000_0000_0000_0010, last);
        in_valid = 1'b0; op = 2'd0; amount = 6'd63; data_in = 64'hFFFF_0000_FFFF_0000;
        @(negedge clk);
        check("R2 out_valid idle", {63'd0, out_valid}, 64'd0);
        check("R3 result held", result, last);
        @(negedge clk);
        check("R3 result held second cycle", result, 64'h0000_0000_0000_00F0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule